// File: doc/BRIEF.md
# Iterative Triple-DES Block Engine

This block encrypts or decrypts one 64-bit block with two-key triple DES. It is started by a one-cycle strobe that captures the block, both keys and the direction. A single Feistel round circuit then runs once per clock for 48 clocks, stepped by a round and pass counter. The result appears on a registered output together with a one-cycle completion pulse.

All sixteen subkeys for each key are formed at once by fixed bit selection: a choice permutation, a cumulative rotation per round and a compression permutation. No sequential key schedule is involved. Encryption runs the cipher forward with the first key, backward with the second key, then forward with the first key again. Decryption runs the mirror sequence. Between passes the half-block swap replaces the final and initial permutations, because the two cancel.

Bit 63 of every 64-bit port is the first bit of the cipher's numbering. Byte 0 of the block therefore sits in bits 63:56. The parameter KEYS_LATCHED chooses between two variants. With the default of 1, registers capture the keys at start. With 0, the keys are used straight from the ports, and the caller must hold them steady for the whole operation.

Top module: `tdes_engine`

## Requirements
- R1: While reset is high and after it is released, done_o is 0 and result_o is 0 until the first operation finishes.
- R2: With decrypt_i = 0 and key1_i equal to key2_i, the result equals single DES encryption under that key. Key 133457799BBCDFF1 with block 0123456789ABCDEF gives 85E813540F0AB405. Key 0E329232EA6D0D73 with block 8787878787878787 gives 0000000000000000. Key 0 with block 0 gives 8CA64DE9C1B123A7.
- R3: With decrypt_i = 1, the engine inverts encryption under the same key pair. Decrypting an encrypted block returns the original, for equal keys (the R2 vectors) and for distinct keys.
- R4: Encryption computes E(key1) of D(key2) of E(key1) of the block. Each single step is the result of a run in which both keys are equal.
- R5: Decryption computes D(key1) of E(key2) of D(key1) of the block.
- R6: If start_i is sampled high on a rising edge while the engine is idle, done_o is high during the cycle after the 48th following rising edge. It stays high for that one cycle only.
- R7: start_i is ignored while an operation is in progress. The running operation keeps its timing and result, and no extra operation follows.
- R8: result_o changes only in a cycle in which done_o is high, and it holds between operations whatever the inputs do.
- R9: start_i is accepted again on the edge right after done_o rises. A start held high gives a new result every 49 cycles.
- R10: key1_i, key2_i, data_i and decrypt_i are sampled only on the edge that accepts start. Changes during the operation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts an operation when the engine is idle |
| decrypt_i | input | 1 | 0 selects encryption, 1 selects decryption |
| key1_i | input | 64 | Key for the first and third passes |
| key2_i | input | 64 | Key for the middle pass |
| data_i | input | 64 | Block to transform |
| result_o | output | 64 | Transformed block, held until the next completion |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The hardest behaviour to see from the ports is which key and which direction each of the three passes uses. Equal keys collapse the engine to single DES, so only distinct keys expose the pass order. The stimulus therefore builds the expected two-key result from three equal-key runs: forward, backward, forward, each fed the previous output. It then compares that chain with one two-key run, for both directions. A second difficulty is a start strobe that lands in the middle of an operation. Pulses and input changes are placed at fixed cycle offsets inside a run, and the bench confirms that the completion time, the result and the idle period afterwards are unchanged.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

   localparam int BLK_W      = 64;
   localparam int HALF_W     = BLK_W / 2;
   localparam int SK_W       = 48;
   localparam int CD_W       = 28;
   localparam int PC1_W      = 2 * CD_W;
   localparam int NUM_ROUNDS = 16;
   localparam int NUM_PASSES = 3;
   localparam int NUM_SBOX   = 8;
   localparam int SBOX_IN_W  = SK_W / NUM_SBOX;
   localparam int SBOX_OUT_W = HALF_W / NUM_SBOX;
   localparam int SBOX_BITS  = (1 << SBOX_IN_W) * SBOX_OUT_W;

   typedef logic [BLK_W-1:0]  blk_t;
   typedef logic [HALF_W-1:0] half_t;
   typedef logic [SK_W-1:0]   subkey_t;
   typedef subkey_t [NUM_ROUNDS-1:0] sched_t;

   // bit-selection tables, entries count bits from 1 = most significant
   localparam logic [0:HALF_W-1][7:0] P_TBL = {
      8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
      8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
      8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
      8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25};

   localparam logic [0:PC1_W-1][7:0] PC1_TBL = {
      8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,  8'd1,
      8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18, 8'd10, 8'd2,
      8'd59, 8'd51, 8'd43, 8'd35, 8'd27, 8'd19, 8'd11, 8'd3,
      8'd60, 8'd52, 8'd44, 8'd36, 8'd63, 8'd55, 8'd47, 8'd39,
      8'd31, 8'd23, 8'd15, 8'd7,  8'd62, 8'd54, 8'd46, 8'd38,
      8'd30, 8'd22, 8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37,
      8'd29, 8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4};

   localparam logic [0:SK_W-1][7:0] PC2_TBL = {
      8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,  8'd3,  8'd28,
      8'd15, 8'd6,  8'd21, 8'd10, 8'd23, 8'd19, 8'd12, 8'd4,
      8'd26, 8'd8,  8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
      8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55, 8'd30, 8'd40,
      8'd51, 8'd45, 8'd33, 8'd48, 8'd44, 8'd49, 8'd39, 8'd56,
      8'd34, 8'd53, 8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

   // substitution boxes, one 4-row by 16-column nibble grid each, row 0 first
   localparam logic [0:NUM_SBOX-1][SBOX_BITS-1:0] SBOX_TBL = {
      256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
      256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
      256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
      256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
      256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
      256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
      256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
      256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

   // source bit of output position i of the initial permutation
   function automatic int ip_src(input int i);
      int row;
      row = i / 8;
      return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * (i % 8);
   endfunction

   function automatic blk_t ip_perm(input blk_t x);
      blk_t y;
      for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
      return y;
   endfunction

   function automatic blk_t fp_perm(input blk_t x);
      blk_t y;
      for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
      return y;
   endfunction

   function automatic subkey_t e_expand(input half_t x);
      subkey_t y;
      int      src;
      for (int i = 0; i < SK_W; i++) begin
         src = 4 * (i / 6) + (i % 6);
         if (src == 0) src = HALF_W;
         if (src == HALF_W + 1) src = 1;
         y[SK_W-1-i] = x[HALF_W-src];
      end
      return y;
   endfunction

   function automatic half_t p_perm(input half_t x);
      half_t y;
      for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(P_TBL[i])];
      return y;
   endfunction

   function automatic logic [PC1_W-1:0] pc1_sel(input blk_t k);
      logic [PC1_W-1:0] y;
      for (int i = 0; i < PC1_W; i++) y[PC1_W-1-i] = k[BLK_W-int'(PC1_TBL[i])];
      return y;
   endfunction

   function automatic subkey_t pc2_sel(input logic [PC1_W-1:0] cd);
      subkey_t y;
      for (int i = 0; i < SK_W; i++) y[SK_W-1-i] = cd[PC1_W-int'(PC2_TBL[i])];
      return y;
   endfunction

   // total left rotation applied to each key half by round n (0-based)
   function automatic int shift_total(input int n);
      int s;
      s = 0;
      for (int i = 0; i <= n; i++)
         s += (i == 0 || i == 1 || i == 8 || i == NUM_ROUNDS - 1) ? 1 : 2;
      return s;
   endfunction

   function automatic logic [CD_W-1:0] rotl_cd(input logic [CD_W-1:0] x, input int n);
      return (x << n) | (x >> (CD_W - n));
   endfunction

   function automatic logic [SBOX_OUT_W-1:0] sbox_lookup(input int b,
                                                         input logic [SBOX_IN_W-1:0] v);
      logic [SBOX_IN_W-1:0] idx;
      idx = {v[SBOX_IN_W-1], v[0], v[SBOX_IN_W-2:1]};
      return SBOX_TBL[b][SBOX_BITS-1-SBOX_OUT_W*int'(idx) -: SBOX_OUT_W];
   endfunction

endpackage

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
   import tdes_pkg::*;
(
   input  blk_t   key_i,
   output sched_t sched_o
);

   logic [PC1_W-1:0] cd;

   assign cd = pc1_sel(key_i);

   // each subkey is a fixed selection of key bits: no state, no stepping
   for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_subkey
      localparam int SH = shift_total(g);
      assign sched_o[g] = pc2_sel({rotl_cd(cd[PC1_W-1 -: CD_W], SH),
                                   rotl_cd(cd[CD_W-1:0], SH)});
   end

endmodule

// File: rtl/tdes_round.sv
module tdes_round
   import tdes_pkg::*;
(
   input  half_t   l_i,
   input  half_t   r_i,
   input  subkey_t sk_i,
   output half_t   l_o,
   output half_t   r_o
);

   subkey_t mixed;
   half_t   subst;

   assign mixed = e_expand(r_i) ^ sk_i;

   for (genvar b = 0; b < NUM_SBOX; b++) begin : g_box
      assign subst[HALF_W-1-SBOX_OUT_W*b -: SBOX_OUT_W] =
         sbox_lookup(b, mixed[SK_W-1-SBOX_IN_W*b -: SBOX_IN_W]);
   end

   assign l_o = r_i;
   assign r_o = l_i ^ p_perm(subst);

endmodule

// File: rtl/tdes_seq.sv
module tdes_seq
   import tdes_pkg::*;
#(
   parameter int ROUNDS = NUM_ROUNDS,
   parameter int PASSES = NUM_PASSES
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start_i,
   output logic                      load_o,
   output logic                      busy_o,
   output logic [$clog2(PASSES)-1:0] pass_o,
   output logic [$clog2(ROUNDS)-1:0] rnd_o,
   output logic                      pass_end_o,
   output logic                      last_o,
   output logic                      done_o
);

   localparam int RW     = $clog2(ROUNDS);
   localparam int PW     = $clog2(PASSES);
   localparam int TOTAL  = ROUNDS * PASSES;
   localparam int SPAN_W = $clog2(TOTAL + 1);

   if (ROUNDS < 2 || PASSES < 2 || (1 << RW) != ROUNDS) begin : g_bad_cfg
      $error("tdes_seq: ROUNDS must be a power of two and PASSES at least 2");
   end

   logic          busy_q, done_q;
   logic [PW-1:0] pass_q;
   logic [RW-1:0] rnd_q;
   logic          rnd_last, last;

   assign rnd_last = (rnd_q == RW'(ROUNDS - 1));
   assign last     = busy_q && rnd_last && (pass_q == PW'(PASSES - 1));
   assign load_o   = start_i && !busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= '0;
         rnd_q  <= '0;
      end else begin
         done_q <= last;
         if (load_o) begin
            busy_q <= 1'b1;
            pass_q <= '0;
            rnd_q  <= '0;
         end else if (busy_q) begin
            rnd_q <= rnd_q + 1'b1;
            if (rnd_last) begin
               pass_q <= pass_q + 1'b1;
               if (last) busy_q <= 1'b0;
            end
         end
      end
   end

   assign busy_o     = busy_q;
   assign pass_o     = pass_q;
   assign rnd_o      = rnd_q;
   assign pass_end_o = busy_q && rnd_last;
   assign last_o     = last;
   assign done_o     = done_q;

   // independent count of busy cycles, used only by the check below
   logic [SPAN_W-1:0] span_q;
   always_ff @(posedge clk) begin
      if (rst)         span_q <= '0;
      else if (load_o) span_q <= '0;
      else if (busy_q) span_q <= span_q + 1'b1;
   end

   assert_span_R6: assert property (@(posedge clk) disable iff (rst)
      done_q |-> span_q == SPAN_W'(TOTAL));

   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      busy_q && start_i && !last |=> busy_q && (rnd_q != '0 || pass_q != '0));

   assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
      done_q && start_i |=> busy_q);

endmodule

// File: rtl/tdes_engine.sv
module tdes_engine
   import tdes_pkg::*;
#(
   parameter int KEYS_LATCHED = 1
)(
   input  logic        clk,
   input  logic        rst,
   input  logic        start_i,
   input  logic        decrypt_i,
   input  logic [63:0] key1_i,
   input  logic [63:0] key2_i,
   input  logic [63:0] data_i,
   output logic [63:0] result_o,
   output logic        done_o
);

   localparam int RW       = $clog2(NUM_ROUNDS);
   localparam int PW       = $clog2(NUM_PASSES);
   localparam int MID_PASS = 1;

   if (KEYS_LATCHED != 0 && KEYS_LATCHED != 1) begin : g_bad_cfg
      $error("tdes_engine: KEYS_LATCHED must be 0 or 1");
   end

   logic          load, busy, pass_end, last;
   logic [PW-1:0] pass;
   logic [RW-1:0] rnd;

   tdes_seq #(.ROUNDS(NUM_ROUNDS), .PASSES(NUM_PASSES)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .load_o     (load),
      .busy_o     (busy),
      .pass_o     (pass),
      .rnd_o      (rnd),
      .pass_end_o (pass_end),
      .last_o     (last),
      .done_o     (done_o)
   );

   blk_t k1_use, k2_use;

   if (KEYS_LATCHED == 1) begin : g_key_regs
      blk_t k1_q, k2_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            k1_q <= '0;
            k2_q <= '0;
         end else if (load) begin
            k1_q <= key1_i;
            k2_q <= key2_i;
         end
      end
      assign k1_use = k1_q;
      assign k2_use = k2_q;
   end else begin : g_key_direct
      assign k1_use = key1_i;
      assign k2_use = key2_i;

      assert_keys_held_R10: assert property (@(posedge clk) disable iff (rst)
         busy |-> $stable(key1_i) && $stable(key2_i));
   end

   sched_t sched1, sched2;

   tdes_key_sched u_sched1 (.key_i(k1_use), .sched_o(sched1));
   tdes_key_sched u_sched2 (.key_i(k2_use), .sched_o(sched2));

   half_t   l_q, r_q, l_nx, r_nx;
   logic    dir_q;
   blk_t    res_q;
   subkey_t sk_cur;
   logic    mid, back;
   logic [RW-1:0] sk_idx;

   // middle pass: other key, opposite direction
   always_comb begin
      mid    = (pass == PW'(MID_PASS));
      back   = dir_q ^ mid;
      sk_idx = back ? (RW'(NUM_ROUNDS - 1) - rnd) : rnd;
      sk_cur = mid ? sched2[sk_idx] : sched1[sk_idx];
   end

   tdes_round u_round (
      .l_i  (l_q),
      .r_i  (r_q),
      .sk_i (sk_cur),
      .l_o  (l_nx),
      .r_o  (r_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         l_q   <= '0;
         r_q   <= '0;
         dir_q <= 1'b0;
         res_q <= '0;
      end else begin
         if (load) begin
            {l_q, r_q} <= ip_perm(data_i);
            dir_q      <= decrypt_i;
         end else if (busy) begin
            if (pass_end) begin
               l_q <= r_nx;
               r_q <= l_nx;
            end else begin
               l_q <= l_nx;
               r_q <= r_nx;
            end
         end
         if (last) res_q <= fp_perm({r_nx, l_nx});
      end
   end

   assign result_o = res_q;

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(result_o) |-> done_o);

endmodule

// File: tb/tdes_engine_tb.sv
module tdes_engine_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        dec = 1'b0;
   logic [63:0] k1 = '0, k2 = '0, din = '0;
   logic [63:0] res;
   logic        done;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   localparam logic [63:0] KA  = 64'h133457799BBCDFF1;
   localparam logic [63:0] PA  = 64'h0123456789ABCDEF;
   localparam logic [63:0] CA  = 64'h85E813540F0AB405;
   localparam logic [63:0] KB  = 64'h0E329232EA6D0D73;
   localparam logic [63:0] PB  = 64'h8787878787878787;
   localparam logic [63:0] CB  = 64'h0000000000000000;
   localparam logic [63:0] CZ  = 64'h8CA64DE9C1B123A7;
   localparam logic [63:0] KX  = 64'h0123456789ABCDEF;
   localparam logic [63:0] KY  = 64'hFEDCBA9876543210;
   localparam logic [63:0] TXT = 64'h4E6F772069732074;

   always #5 clk = ~clk;

   tdes_engine u_dut (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start),
      .decrypt_i (dec),
      .key1_i    (k1),
      .key2_i    (k2),
      .data_i    (din),
      .result_o  (res),
      .done_o    (done)
   );

   task automatic check64(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_int(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one operation; checks the completion time and the pulse width
   task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                     input logic m, output logic [63:0] r);
      int cyc;
      @(negedge clk);
      k1 = a; k2 = b; din = d; dec = m; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      check_int("R6", "cycles from start to done", cyc, 48);
      r = res;
      @(posedge clk);
      @(negedge clk);
      check_int("R6", "done width", int'(done), 0);
   endtask

   task automatic test_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_int("R1", "done in reset", int'(done), 0);
      check64("R1", "result in reset", res, '0);
      rst = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_int("R1", "done after reset", int'(done), 0);
      check64("R1", "result after reset", res, '0);
   endtask

   task automatic test_single_enc();
      logic [63:0] r;
      op(KA, KA, PA, 1'b0, r);  check64("R2", "vector A encrypt", r, CA);
      op(KB, KB, PB, 1'b0, r);  check64("R2", "vector B encrypt", r, CB);
      op('0, '0, '0, 1'b0, r);  check64("R2", "zero vector encrypt", r, CZ);
   endtask

   task automatic test_decrypt();
      logic [63:0] r, c;
      op(KA, KA, CA, 1'b1, r);  check64("R3", "vector A decrypt", r, PA);
      op(KB, KB, CB, 1'b1, r);  check64("R3", "vector B decrypt", r, PB);
      op('0, '0, CZ, 1'b1, r);  check64("R3", "zero vector decrypt", r, '0);
      op(KX, KY, TXT, 1'b0, c);
      op(KX, KY, c, 1'b1, r);   check64("R3", "two-key round trip", r, TXT);
   endtask

   task automatic test_enc_order();
      logic [63:0] y, t1, t2, t3;
      op(KA, KX, TXT, 1'b0, y);
      op(KA, KA, TXT, 1'b0, t1);
      op(KX, KX, t1, 1'b1, t2);
      op(KA, KA, t2, 1'b0, t3);
      check64("R4", "E(k1) D(k2) E(k1) chain", y, t3);
   endtask

   task automatic test_dec_order();
      logic [63:0] u, s1, s2, s3;
      op(KA, KX, PB, 1'b1, u);
      op(KA, KA, PB, 1'b1, s1);
      op(KX, KX, s1, 1'b0, s2);
      op(KA, KA, s2, 1'b1, s3);
      check64("R5", "D(k1) E(k2) D(k1) chain", u, s3);
   endtask

   // start pulses mid-run with other data must be ignored
   task automatic test_busy_start();
      int early, extra;
      logic seen;
      early = 0; extra = 0; seen = 1'b0;
      @(negedge clk);
      k1 = KA; k2 = KA; din = PA; dec = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 1; cyc <= 48; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         if (cyc < 48 && done) early++;
         if (cyc == 48) seen = done;
         if (cyc == 10 || cyc == 30) begin din = PB; start = 1'b1; end
         if (cyc == 11 || cyc == 31) start = 1'b0;
      end
      check_int("R7", "early done", early, 0);
      check_int("R7", "done on time", int'(seen), 1);
      check64("R7", "result kept", res, CA);
      for (int cyc = 0; cyc < 60; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         if (done) extra++;
      end
      check_int("R7", "no extra operation", extra, 0);
   endtask

   // inputs changed after the accepted start must not matter
   task automatic test_late_inputs();
      logic seen;
      seen = 1'b0;
      @(negedge clk);
      k1 = KB; k2 = KB; din = PB; dec = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 1; cyc <= 48; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         if (cyc == 5) begin k1 = KX; k2 = KY; din = TXT; dec = 1'b1; end
         if (cyc == 48) seen = done;
      end
      check_int("R10", "done on time", int'(seen), 1);
      check64("R10", "result from sampled inputs", res, CB);
   endtask

   task automatic test_hold();
      logic [63:0] r;
      int moved, pulses;
      moved = 0; pulses = 0;
      op(KA, KA, PA, 1'b0, r);
      for (int cyc = 0; cyc < 20; cyc++) begin
         @(negedge clk);
         k1 = {k1[62:0], ~k1[63]}; din = din ^ 64'h5A5A_0F0F_3C3C_9696; dec = ~dec;
         @(posedge clk);
         @(negedge clk);
         if (res !== CA) moved++;
         if (done) pulses++;
      end
      check_int("R8", "result changes while idle", moved, 0);
      check_int("R8", "done pulses while idle", pulses, 0);
   endtask

   // start held high: second operation starts on the edge after done
   task automatic test_back_to_back();
      int gap, cyc;
      logic [63:0] first;
      @(negedge clk);
      k1 = KA; k2 = KA; din = PA; dec = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      din = PB; k1 = KB; k2 = KB;
      cyc = 0;
      while (done !== 1'b1 && cyc < 100) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      check_int("R9", "first done time", cyc, 48);
      first = res;
      check64("R9", "first result", first, CA);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      gap = 1;
      while (done !== 1'b1 && gap < 100) begin
         @(posedge clk);
         @(negedge clk);
         gap++;
      end
      check_int("R9", "done to done spacing", gap, 49);
      check64("R9", "second result", res, CB);
   endtask

   initial begin
      test_reset();
      test_single_enc();
      test_decrypt();
      test_enc_order();
      test_dec_order();
      test_busy_start();
      test_late_inputs();
      test_hold();
      test_back_to_back();
      repeat (5) @(posedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule